// File: doc/BRIEF.md
# Four-Mode Addressable Bit Latch

This block keeps eight bits of state that are loaded one at a time from a single data line. A 3-bit select input picks the bit to be written, and all eight bits are always visible on a parallel active-high output bus. It is used for serial-to-parallel loading of control bits and for scattered single-bit updates. It can also act as a one-hot decoder or demultiplexer.

Two active-low controls set the mode. A write strobe and a clear input combine into four behaviours: write the selected bit, hold every bit, drive only the selected output with the data while forcing the rest low, and force all bits low. The block is fully synchronous. Every rising clock edge samples the data, select and controls and updates the register, so the outputs reflect the inputs one clock later. An asynchronous active-low reset, released in step with the clock, sets all state to zero. A side output gives a one-cycle warning when the select changes by more than one bit between two consecutive write-enabled cycles. The select is only meant to move while the block holds.

Top module: `addr_bit_latch`

## Requirements
- R1: While `rst_n` is low, `q` is 8'h00 and `addr_warn` is 0, immediately and without a clock edge. After release, the block stays in that state until it samples its first inputs.
- R2: With `wr_en_n`=0 and `clr_n`=1 at a rising edge, bit `q[sel]` (select value n addresses `q[n]`) takes `din` after that edge. Every other bit keeps its value.
- R3: With `wr_en_n`=1 and `clr_n`=1 at a rising edge, `q` keeps its value whatever `din` and `sel` are.
- R4: With `wr_en_n`=0 and `clr_n`=0 at a rising edge, `q[sel]` becomes `din` and every other bit becomes 0. With `din`=1 this gives `q` = 1<<`sel`.
- R5: With `wr_en_n`=1 and `clr_n`=0 at a rising edge, `q` becomes 8'h00 whatever `din` and `sel` are.
- R6: The value a bit keeps after the strobe returns high is the `din` level sampled at the last write-enabled edge.
- R7: After a change from demultiplex mode to hold, `q` keeps the pattern of the last demultiplex edge.
- R8: `addr_warn` is 1 for the cycle after an edge at which `wr_en_n` was 0 at this edge and at the previous edge, and `sel` differs from its previous sampled value in two or more bit positions. That write still goes to the new `sel`.
- R9: `addr_warn` stays 0 when the select changes by one bit or less between write-enabled edges. It also stays 0 when the strobe was high at either of the two edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| din | input | 1 | Serial data bit |
| sel | input | 3 | Bit select |
| wr_en_n | input | 1 | Active-low write strobe |
| clr_n | input | 1 | Active-low clear |
| q | output | 8 | Stored bits, active high |
| addr_warn | output | 1 | One-cycle warning for an unsafe select change |

## Verification
Assertions check the mode rules on every cycle after reset. A hold edge must leave `q` unchanged. A clear edge must zero it. A demultiplex edge must leave at most one bit set. A write edge must change only the selected bit, and that bit must match the sampled data. A warning must follow a write-enabled edge with a multi-bit select change. The bench scenarios show the things a property over one cycle cannot show: that a value survives a long run of hold cycles, the exact patterns after mode sequences, a full decoder sweep, and the asynchronous effect of reset between clock edges.

// File: rtl/abl_pkg.sv
package abl_pkg;
  typedef enum logic [1:0] {
    MODE_WRITE = 2'd0,
    MODE_HOLD  = 2'd1,
    MODE_DEMUX = 2'd2,
    MODE_CLEAR = 2'd3
  } abl_mode_e;

  function automatic abl_mode_e decode_mode(input logic wr_en_n, input logic clr_n);
    case ({wr_en_n, clr_n})
      2'b01:   return MODE_WRITE;
      2'b11:   return MODE_HOLD;
      2'b00:   return MODE_DEMUX;
      default: return MODE_CLEAR;
    endcase
  endfunction
endpackage

// File: rtl/abl_sel_dec.sv
module abl_sel_dec #(
  parameter int ADDR_W = 3,
  localparam int NBITS = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] sel,
  output logic [NBITS-1:0]  sel_1h
);
  for (genvar i = 0; i < NBITS; i++) begin : g_line
    assign sel_1h[i] = (sel == ADDR_W'(i));
  end

  always_comb begin
    a_onehot_r2: assert ($onehot(sel_1h) || $isunknown(sel));
  end
endmodule

// File: rtl/abl_store.sv
module abl_store
  import abl_pkg::*;
#(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  abl_mode_e        mode,
  input  logic             din,
  input  logic [NBITS-1:0] sel_1h,
  output logic [NBITS-1:0] q
);
  logic [NBITS-1:0] q_r;
  logic [NBITS-1:0] q_nxt;
  logic             upd;

  assign upd = (mode != MODE_HOLD);

  for (genvar b = 0; b < NBITS; b++) begin : g_bit
    always_comb begin
      case (mode)
        MODE_WRITE: q_nxt[b] = sel_1h[b] ? din : q_r[b];
        MODE_DEMUX: q_nxt[b] = sel_1h[b] & din;
        MODE_CLEAR: q_nxt[b] = 1'b0;
        default:    q_nxt[b] = q_r[b];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q_r <= '0;
    else if (upd) q_r <= q_nxt;
  end

  assign q = q_r;

  p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HOLD) |=> $stable(q_r));
  p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_CLEAR) |=> (q_r == '0));
  p_demux_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_DEMUX) |=> $onehot0(q_r));
  p_write_others_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_WRITE) |=> (((q_r ^ $past(q_r)) & ~$past(sel_1h)) == '0));
  p_write_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_WRITE) |=> (((q_r & $past(sel_1h)) != '0) == $past(din)));
endmodule

// File: rtl/abl_addr_guard.sv
module abl_addr_guard #(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_n,
  input  logic [ADDR_W-1:0] sel,
  output logic              warn
);
  logic [ADDR_W-1:0] sel_prev;
  logic              en_prev_n;
  logic              warn_r;
  logic              warn_nxt;
  logic [ADDR_W-1:0] diff;

  assign diff     = sel ^ sel_prev;
  assign warn_nxt = !wr_en_n && !en_prev_n && ($countones(diff) > 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_prev  <= '0;
      en_prev_n <= 1'b1;
      warn_r    <= 1'b0;
    end else begin
      sel_prev  <= sel;
      en_prev_n <= wr_en_n;
      warn_r    <= warn_nxt;
    end
  end

  assign warn = warn_r;

  p_warn_needs_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    warn_r |-> !$past(wr_en_n));
  p_single_step_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(sel ^ sel_prev) <= 1) |=> !warn_r);
  p_multi_step_warns_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_n && !en_prev_n && ($countones(sel ^ sel_prev) > 1)) |=> warn_r);
endmodule

// File: rtl/addr_bit_latch.sv
module addr_bit_latch
  import abl_pkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int NBITS = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              din,
  input  logic [ADDR_W-1:0] sel,
  input  logic              wr_en_n,
  input  logic              clr_n,
  output logic [NBITS-1:0]  q,
  output logic              addr_warn
);
  logic             rst_s1_n;
  logic             rst_s2_n;
  abl_mode_e        mode;
  logic [NBITS-1:0] sel_1h;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_n <= 1'b0;
      rst_s2_n <= 1'b0;
    end else begin
      rst_s1_n <= 1'b1;
      rst_s2_n <= rst_s1_n;
    end
  end

  assign mode = decode_mode(wr_en_n, clr_n);

  abl_sel_dec #(.ADDR_W(ADDR_W)) u_dec (
    .sel    (sel),
    .sel_1h (sel_1h)
  );

  abl_store #(.NBITS(NBITS)) u_store (
    .clk    (clk),
    .rst_n  (rst_s2_n),
    .mode   (mode),
    .din    (din),
    .sel_1h (sel_1h),
    .q      (q)
  );

  abl_addr_guard #(.ADDR_W(ADDR_W)) u_guard (
    .clk     (clk),
    .rst_n   (rst_s2_n),
    .wr_en_n (wr_en_n),
    .sel     (sel),
    .warn    (addr_warn)
  );

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_s2_n |-> (q == '0 && !addr_warn));
endmodule

// File: tb/addr_bit_latch_test.sv
module addr_bit_latch_test;
  logic       clk;
  logic       rst_n;
  logic       din;
  logic [2:0] sel;
  logic       wr_en_n;
  logic       clr_n;
  logic [7:0] q;
  logic       addr_warn;
  int checks;
  int errors;
  bit done;

  addr_bit_latch uut (
    .clk(clk), .rst_n(rst_n), .din(din), .sel(sel),
    .wr_en_n(wr_en_n), .clr_n(clr_n), .q(q), .addr_warn(addr_warn)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // row: {wr_en_n, clr_n, din, sel[2:0], expected q[7:0], expected warn}
  localparam int NV = 19;
  localparam logic [14:0] VEC [NV] = '{
    {1'b0, 1'b1, 1'b1, 3'd3, 8'h08, 1'b0},
    {1'b0, 1'b1, 1'b1, 3'd2, 8'h0C, 1'b0},
    {1'b0, 1'b1, 1'b0, 3'd3, 8'h04, 1'b0},
    {1'b1, 1'b1, 1'b1, 3'd7, 8'h04, 1'b0},  // R3 inputs ignored
    {1'b1, 1'b1, 1'b0, 3'd0, 8'h04, 1'b0},  // R9 move while holding
    {1'b0, 1'b1, 1'b1, 3'd0, 8'h05, 1'b0},
    {1'b0, 1'b1, 1'b1, 3'd3, 8'h0D, 1'b1},  // R8 two bits change, new target
    {1'b0, 1'b1, 1'b1, 3'd7, 8'h8D, 1'b0},
    {1'b0, 1'b1, 1'b0, 3'd7, 8'h0D, 1'b0},  // R6 last data level
    {1'b1, 1'b1, 1'b1, 3'd7, 8'h0D, 1'b0},  // R6 kept after strobe high
    {1'b0, 1'b0, 1'b1, 3'd5, 8'h20, 1'b0},
    {1'b0, 1'b0, 1'b0, 3'd5, 8'h00, 1'b0},
    {1'b0, 1'b0, 1'b1, 3'd4, 8'h10, 1'b0},
    {1'b1, 1'b1, 1'b0, 3'd0, 8'h10, 1'b0},  // R7 pattern kept
    {1'b1, 1'b0, 1'b1, 3'd6, 8'h00, 1'b0},
    {1'b0, 1'b1, 1'b1, 3'd6, 8'h40, 1'b0},
    {1'b0, 1'b1, 1'b1, 3'd1, 8'h42, 1'b1},  // R8 three bits
    {1'b0, 1'b1, 1'b1, 3'd2, 8'h46, 1'b1},  // R8 back-to-back pulse
    {1'b1, 1'b0, 1'b0, 3'd0, 8'h00, 1'b0}
  };

  task automatic chk(input string tag, input logic [7:0] expq, input logic expw);
    checks++;
    if (q !== expq || addr_warn !== expw) begin
      errors++;
      $display("FAIL %s: q=%h warn=%b expected q=%h warn=%b", tag, q, addr_warn, expq, expw);
    end
  endtask

  task automatic step(input logic en_n, input logic cl_n, input logic d, input logic [2:0] a);
    @(negedge clk);
    wr_en_n = en_n; clr_n = cl_n; din = d; sel = a;
    @(posedge clk);
    #1;
  endtask

  function automatic string tag_of(input logic en_n, input logic cl_n, input logic w);
    if (w) return "R8";
    case ({en_n, cl_n})
      2'b01:   return "R2";
      2'b11:   return "R3";
      2'b00:   return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    done = 1'b0;
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: q=%h expected run to end", q);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0; din = 1'b0; sel = 3'd0; wr_en_n = 1'b1; clr_n = 1'b1;
    #1;
    chk("R1", 8'h00, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", 8'h00, 1'b0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][14], VEC[i][13], VEC[i][12], VEC[i][11:9]);
      chk(tag_of(VEC[i][14], VEC[i][13], VEC[i][0]), VEC[i][8:1], VEC[i][0]);
    end

    // R4 decoder sweep in Gray order (single-bit select steps, so R9: no warning)
    for (int i = 0; i < 8; i++) begin
      logic [2:0] g;
      g = 3'(i ^ (i >> 1));
      step(1'b0, 1'b0, 1'b1, g);
      chk("R4", 8'h01 << g, 1'b0);
    end

    // R5 clear ignores data and select
    step(1'b1, 1'b0, 1'b1, 3'd7);
    chk("R5", 8'h00, 1'b0);

    // R3 long hold keeps a written pattern
    step(1'b0, 1'b1, 1'b1, 3'd7);
    step(1'b0, 1'b1, 1'b1, 3'd6);
    for (int i = 0; i < 6; i++) begin
      step(1'b1, 1'b1, 1'(i), 3'(i));
      chk("R3", 8'hC0, 1'b0);
    end

    // R8 warn set, then R1 asynchronous reset between edges
    step(1'b0, 1'b1, 1'b1, 3'd0);
    step(1'b0, 1'b1, 1'b1, 3'd5);
    chk("R8", 8'hE1, 1'b1);
    @(negedge clk); rst_n = 1'b0;
    #0.5;
    chk("R1", 8'h00, 1'b0);
    @(posedge clk); #1;
    @(negedge clk); rst_n = 1'b1; wr_en_n = 1'b1; clr_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", 8'h00, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule